// File: doc/BRIEF.md
# Differential Branch Trace Encoder

This block turns a stream of program-flow events into short messages on a narrow trace port. Each event carries one 32-bit address and a kind: a branch target or a memory access. Every branch event is traced. A memory access is traced only when one of two programmable address windows accepts it.

To keep messages short, the encoder keeps a reference: the last address it actually sent. It transmits only the low-order part of the new address that differs from that reference. The part sent is 4, 8, 16 or 32 bits, and the shortest part that still carries the whole difference is chosen. A header nibble marked by a sync strobe opens each message and gives its length code.

The port can carry only one message at a time. If a qualified event arrives while a message is still going out, a mode input decides what happens. In realtime mode the new event is discarded and the next message flags the loss. In non-realtime mode a stall is raised to the processor, which holds the event until the port can take it.

Top module: `trace_diff_enc`

## Requirements
- R1: After reset the port is idle (`tp_valid`, `tp_sync` and `cpu_stall` low), the reference address is 0 and the lost flag is clear.
- R2: An accepted event produces a header nibble in the next cycle, with `tp_sync` high and `tp_valid` high. The header bits are: [1:0] length code, [2] kind (1 = memory access), [3] lost flag. The address nibbles follow in the cycles after it, least significant nibble first, with `tp_sync` low.
- R3: If address bits [31:4] equal the reference, the length code is 0 and one address nibble is sent.
- R4: Otherwise, if bits [31:8] equal the reference, the code is 1 and two nibbles are sent.
- R5: Otherwise, if bits [31:16] equal the reference, the code is 2 and four nibbles are sent.
- R6: Otherwise the code is 3 and all eight nibbles of the address are sent.
- R7: The reference changes to the event address only when a message is accepted. Dropped and unqualified events leave it unchanged.
- R8: In realtime mode (`rt_mode`=1), a qualified event that arrives while a message is out and not on its last nibble is discarded. The current message completes unchanged.
- R9: A discard in realtime mode sets the lost flag. The next accepted header carries it in bit 3, and accepting that header clears the flag.
- R10: In non-realtime mode, a qualified event blocked in the same way raises `cpu_stall` in that same cycle. The event is taken once the port frees up.
- R11: A memory access qualifies when, in either window, lo ≤ address ≤ hi (both bounds inclusive) and the window's select enables its direction. Select bit 0 enables reads and bit 1 enables writes.
- R12: An unqualified memory access sends nothing, raises no stall and does not set the lost flag.
- R13: An event presented during the last nibble of a message is accepted, and its header follows in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_mode | input | 1 | 1 = drop blocked events, 0 = stall the processor |
| ev_valid | input | 1 | Event present this cycle |
| ev_mem | input | 1 | 1 = memory access, 0 = branch |
| ev_write | input | 1 | Direction of a memory access (1 = write) |
| ev_addr | input | 32 | Event address |
| w0_lo | input | 32 | Window 0 lower bound |
| w0_hi | input | 32 | Window 0 upper bound |
| w0_sel | input | 2 | Window 0 enables: bit0 read, bit1 write |
| w1_lo | input | 32 | Window 1 lower bound |
| w1_hi | input | 32 | Window 1 upper bound |
| w1_sel | input | 2 | Window 1 enables: bit0 read, bit1 write |
| cpu_stall | output | 1 | Hold the current event (non-realtime mode only) |
| tp_valid | output | 1 | Trace nibble valid |
| tp_sync | output | 1 | Marks the header nibble |
| tp_data | output | 4 | Trace nibble |

## Verification
An event accepted at a clock edge shows its header in the cycle that follows that edge. Each address nibble then comes one cycle later than the one before it. `cpu_stall` is combinational and is due in the same cycle as the blocked event. The reference model in the bench holds a queue of the nibbles it expects. Trace outputs are compared against the head of that queue at every falling edge, and the stall is compared a few time units after the inputs settle. The back-to-back, drop and stall cases are each timed against the queue length, so an event lands exactly on the last nibble or in the middle of a message.

// File: rtl/trace_diff_enc.sv
module trace_diff_enc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rt_mode,
  input  logic        ev_valid,
  input  logic        ev_mem,
  input  logic        ev_write,
  input  logic [31:0] ev_addr,
  input  logic [31:0] w0_lo,
  input  logic [31:0] w0_hi,
  input  logic [1:0]  w0_sel,
  input  logic [31:0] w1_lo,
  input  logic [31:0] w1_hi,
  input  logic [1:0]  w1_sel,
  output logic        cpu_stall,
  output logic        tp_valid,
  output logic        tp_sync,
  output logic [3:0]  tp_data
);
  logic [31:0] ref_q;
  logic [35:0] sh_q;
  logic [3:0]  left_q;
  logic        first_q, lost_q;
  logic [1:0]  code;
  logic [3:0]  total;

  wire in0 = (ev_addr >= w0_lo) && (ev_addr <= w0_hi) && (ev_write ? w0_sel[1] : w0_sel[0]);
  wire in1 = (ev_addr >= w1_lo) && (ev_addr <= w1_hi) && (ev_write ? w1_sel[1] : w1_sel[0]);
  wire qual   = ev_valid && (!ev_mem || in0 || in1);
  wire busy   = left_q != 4'd0;
  wire free   = !busy || left_q == 4'd1;
  wire accept = qual && free;
  wire block  = qual && !free;
  wire drop   = block && rt_mode;

  always_comb begin
    if (ev_addr[31:4] == ref_q[31:4])        begin code = 2'd0; total = 4'd2; end
    else if (ev_addr[31:8] == ref_q[31:8])   begin code = 2'd1; total = 4'd3; end
    else if (ev_addr[31:16] == ref_q[31:16]) begin code = 2'd2; total = 4'd5; end
    else                                     begin code = 2'd3; total = 4'd9; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q   <= '0;
      sh_q    <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      if (accept) begin
        sh_q    <= {ev_addr, lost_q, ev_mem, code};
        left_q  <= total;
        first_q <= 1'b1;
        ref_q   <= ev_addr;
        lost_q  <= 1'b0;
      end else begin
        if (busy) begin
          sh_q   <= sh_q >> 4;
          left_q <= left_q - 4'd1;
        end
        first_q <= 1'b0;
        if (drop) lost_q <= 1'b1;
      end
    end
  end

  assign cpu_stall = block && !rt_mode;
  assign tp_valid  = busy;
  assign tp_sync   = first_q;
  assign tp_data   = busy ? sh_q[3:0] : 4'd0;
endmodule

module trace_diff_enc_chk (
  input logic clk,
  input logic rst_n,
  input logic rt_mode,
  input logic cpu_stall,
  input logic tp_valid,
  input logic tp_sync
);
  // R2
  sync_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) tp_sync |-> tp_valid);
  // R2
  hdr_then_addr_chk: assert property (@(posedge clk) disable iff (!rst_n) tp_sync |=> tp_valid && !tp_sync);
  // R8
  rt_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) rt_mode |-> !cpu_stall);
  // R10
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) cpu_stall |-> tp_valid);
  // R10
  stall_keeps_port_chk: assert property (@(posedge clk) disable iff (!rst_n) cpu_stall |=> tp_valid);
endmodule

bind trace_diff_enc trace_diff_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rt_mode(rt_mode),
  .cpu_stall(cpu_stall), .tp_valid(tp_valid), .tp_sync(tp_sync)
);

// File: tb/trace_diff_enc_tb.sv
module trace_diff_enc_tb;
  logic clk = 0, rst_n = 0, rt_mode = 1;
  logic ev_valid = 0, ev_mem = 0, ev_write = 0;
  logic [31:0] ev_addr = 0;
  logic [31:0] w0_lo = 32'h1000, w0_hi = 32'h10FF, w1_lo = 32'h2000, w1_hi = 32'h2FFF;
  logic [1:0]  w0_sel = 2'b01, w1_sel = 2'b10;
  logic cpu_stall, tp_valid, tp_sync;
  logic [3:0] tp_data;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";
  logic [4:0] q[$];
  logic [31:0] m_ref = 0;
  bit m_lost = 0, m_stalled = 0, done = 0;

  always #10 clk = ~clk;

  trace_diff_enc u_dut (.*);

  function automatic bit m_qual();
    bit h0, h1;
    h0 = ev_addr >= w0_lo && ev_addr <= w0_hi && (ev_write ? w0_sel[1] : w0_sel[0]);
    h1 = ev_addr >= w1_lo && ev_addr <= w1_hi && (ev_write ? w1_sel[1] : w1_sel[0]);
    return ev_valid && (!ev_mem || h0 || h1);
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // reference model: queue of {sync, nibble} the port must show
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ref = 0; m_lost = 0; m_stalled = 0;
    end else begin
      bit qual, free;
      int n, code;
      qual = m_qual();
      free = q.size() <= 1;
      m_stalled = qual && !free && !rt_mode;
      if (q.size() > 0) void'(q.pop_front());
      if (qual && free) begin
        n = 0;
        for (int s = 4; s <= 32; s = s * 2) begin
          if (n == 0 && ((ev_addr ^ m_ref) >> s) == 0) n = s / 4;
          if (n == 0 && s == 32) n = 8;
        end
        code = (n == 1) ? 0 : (n == 2) ? 1 : (n == 4) ? 2 : 3;
        q.push_back({1'b1, m_lost, ev_mem, 2'(code)});
        for (int i = 0; i < n; i++) q.push_back({1'b0, 4'((ev_addr >> (4 * i)) & 32'hF)});
        m_ref = ev_addr; m_lost = 0;
      end else if (qual && rt_mode) m_lost = 1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (q.size() > 0) begin
      chk(tp_valid && tp_sync == q[0][4] && tp_data == q[0][3:0], "port",
          {tp_valid, tp_sync, tp_data}, {1'b1, q[0]});
    end else chk(!tp_valid && !tp_sync, "idle", {tp_valid, tp_sync}, 0);
    #4 chk(cpu_stall == (m_qual() && q.size() > 1 && !rt_mode), "stall",
           cpu_stall, m_qual() && q.size() > 1 && !rt_mode);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic send(bit mem, bit wr, logic [31:0] a);
    do begin
      @(negedge clk); #2;
      ev_valid = 1; ev_mem = mem; ev_write = wr; ev_addr = a;
      @(posedge clk); #1;
    end while (m_stalled);
    @(negedge clk); #1 ev_valid = 0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_q(int n);
    while (q.size() != n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tp_valid && !tp_sync && !cpu_stall, "reset", {tp_valid, tp_sync, cpu_stall}, 0);
    rst_n = 1;
    cur_req = "R6"; send(0, 0, 32'h12345678); // full 9-nibble message, lsb first
    cur_req = "R8"; wait_q(5); send(0, 0, 32'hDEAD0000); // dropped mid-message
    drain();
    cur_req = "R9"; send(0, 0, 32'h12345679); // R3 code 0, lost flag set, ref unchanged (R7)
    drain();
    cur_req = "R4"; send(0, 0, 32'h123456A0);
    drain();
    cur_req = "R5"; send(0, 0, 32'h1234ABCD);
    cur_req = "R13"; wait_q(1); send(0, 0, 32'h1234ABC0); // back to back
    drain();
    cur_req = "R11"; send(1, 0, 32'h00001080); drain();
    send(1, 1, 32'h00002FFF); drain();
    cur_req = "R12"; send(1, 1, 32'h00001080); drain();
    send(1, 1, 32'h00003000); drain();
    send(1, 0, 32'h00000FFF); drain();
    send(0, 0, 32'h00000001);
    wait_q(3); send(1, 0, 32'h00002000); // unqualified while busy: no loss
    drain();
    cur_req = "R7"; send(0, 0, 32'h00000002); drain();
    cur_req = "R10"; rt_mode = 0;
    send(0, 0, 32'hCAFE0000);
    wait_q(6); send(0, 0, 32'hCAFE0010); // stalled, then sent
    drain();
    send(1, 1, 32'h00002004);
    wait_q(4); send(0, 0, 32'h00002005);
    drain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule